// File: doc/BRIEF.md
# Fixed-Order Chained Rail Sequencer

This block brings four supply rails up and down in a hard-wired order. Rails come up as A, B, C, D and go down as D, C, B, A. No per-channel delay is programmed. Each step waits for a status flag from the rail that went before it: a "fully on" flag while rising, a "fully off" flag while falling. The analog ramps happen outside the block. The block only sees these two flag sets and drives one gate-enable bit per rail.

Four undervoltage-OK inputs are first cleaned by a consecutive-cycle deglitcher. The block starts a power-up only after all four filtered flags and the active-low enable have held together for a qualification window. A power-good output goes high a fixed number of cycles after the last rail reports fully on. It drops on the same edge that a turn-off or a fault begins. A filtered undervoltage in any active state clears every gate at once, and the block must then qualify again. Deasserting the enable while rails are still rising stops the rise and unwinds, in reverse order, only the rails already enabled.

Top module: `rail_chain_seq`

## Requirements
- R1: After reset, once all four raw undervoltage-OK inputs are high and `en_n` is low, `gate_en[0]` rises exactly FILT_LEN + QUAL_LEN + 1 clock edges later. If the filtered flags are already good, it rises QUAL_LEN + 1 edges after `en_n` falls. Until then `gate_en` stays 0.
- R2: While rising, `gate_en[k+1]` is set on the edge that samples `gate_on[k]` high while channel k is the rail being raised. `gate_en` is always a contiguous run of ones starting at bit 0 (bit 0 = rail A, bit 3 = rail D).
- R3: When `en_n` is sampled high with all rails on, `gate_en[3]` clears on that edge. `gate_en[k-1]` then clears on the edge that samples `gate_off[k]` high. After `gate_off[0]` is seen, the block returns to idle.
- R4: While `en_n` is high, no `gate_en` bit ever goes from 0 to 1. From idle with `en_n` high, all gates stay off however long the rails are good.
- R5: `pwr_good` goes high PG_LEN edges after the edge that samples `gate_on[3]` high in the last rising step. It is low whenever not all gates are enabled, and it falls on the edge that samples `en_n` high.
- R6: A raw undervoltage-OK input that is low for fewer than FILT_LEN consecutive cycles has no effect. One that is low for FILT_LEN consecutive cycles makes that channel's filtered flag low.
- R7: When any filtered flag is low while a gate is enabled, all of `gate_en` and `pwr_good` clear on the next edge. The block goes idle and needs a fresh qualification (R1 timing) before it powers up again.
- R8: If `en_n` is sampled high during the rise, the remaining rising steps are dropped. The highest enabled gate clears on that edge, and the lower ones clear one by one through the R3 `gate_off` chain.
- R9: A `gate_on` flag of a channel other than the one being raised does not advance the rise.
- R10: During and just after synchronous reset (`rst_n` low), `gate_en` is 0 and `pwr_good` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| uv_ok | input | 4 | Raw undervoltage-OK flag per rail, bit 0 = rail A |
| en_n | input | 1 | Active-low sequencing enable |
| gate_on | input | 4 | Per-rail fully-on status |
| gate_off | input | 4 | Per-rail fully-off status |
| gate_en | output | 4 | Per-rail gate enable, bit 0 = rail A |
| pwr_good | output | 1 | High once all rails are up and settled |

## Verification
The bench builds the block with FILT_LEN = 4, QUAL_LEN = 20 and PG_LEN = 10 in place of the millisecond-scale defaults. With these values the full qualification window, the settle delay and a sub-threshold glitch each take a few dozen cycles, so every edge count in R1, R5 and R6 can be checked exactly. The short windows also let one run cover a full rise and fall, a fault with requalification, an abort in mid-rise and a held-off enable.

// File: rtl/rcs_pkg.sv
// Package: shared types for the chained rail sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package rcs_pkg;

    // Sequencer phase
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RISE = 2'd1,
        PH_ON   = 2'd2,
        PH_FALL = 2'd3
    } seq_phase_t;

    // Width of a counter that must hold values 0..max_val
    function automatic int unsigned cnt_width(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/rcs_deglitch.sv
// Module: single-bit deglitcher. The output follows the input only after
// the input has differed from the output for FILT_LEN consecutive cycles.
// Assumes: input already synchronous to clk; output resets low (not good).
module rcs_deglitch #(
    parameter int unsigned FILT_LEN = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic clean_out
);
    import rcs_pkg::*;

    localparam int unsigned CW = cnt_width(FILT_LEN);
    localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

    logic [CW-1:0] run_cnt;

    // Count consecutive disagreeing cycles; flip the output at the limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt   <= '0;
            clean_out <= 1'b0;
        end else if (raw_in == clean_out) begin
            run_cnt   <= '0;
        end else if (run_cnt == LAST) begin
            run_cnt   <= '0;
            clean_out <= raw_in;
        end else begin
            run_cnt   <= run_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/rcs_qualify.sv
// Module: qualification timer. Reports ready once cond has held for
// QUAL_LEN consecutive cycles while armed.
// Assumes: arm is high only while the sequencer is idle.
module rcs_qualify #(
    parameter int unsigned QUAL_LEN = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic cond,
    output logic ready
);
    import rcs_pkg::*;

    localparam int unsigned CW = cnt_width(QUAL_LEN);
    localparam logic [CW-1:0] FULL = CW'(QUAL_LEN);

    logic [CW-1:0] hold_cnt;

    // Saturating count of cycles with the start condition held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cnt <= '0;
        end else if (!arm || !cond) begin
            hold_cnt <= '0;
        end else if (hold_cnt != FULL) begin
            hold_cnt <= hold_cnt + 1'b1;
        end
    end

    // Window complete
    always_comb ready = arm && cond && (hold_cnt == FULL);

endmodule

// File: rtl/rcs_chain_fsm.sv
// Module: chained order state machine. Raises gates from index 0 upward,
// each after the previous reports fully on; lowers them from the top down,
// each after the one above reports fully off. A fault clears all gates.
// Assumes: all_good is the AND of filtered undervoltage flags.
module rcs_chain_fsm #(
    parameter int unsigned N_CH = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   all_good,
    input  logic                   en_act,
    input  logic [N_CH-1:0]        gate_on,
    input  logic [N_CH-1:0]        gate_off,
    output logic [N_CH-1:0]        gate_en,
    output rcs_pkg::seq_phase_t    phase
);
    import rcs_pkg::*;

    localparam int unsigned IW = (N_CH > 1) ? $clog2(N_CH) : 1;
    localparam logic [IW-1:0] TOP = IW'(N_CH - 1);

    logic [IW-1:0] idx;

    // Step through the fixed order, abort on fault or disable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            idx     <= '0;
            gate_en <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    gate_en <= '0;
                    if (start) begin
                        phase      <= PH_RISE;
                        idx        <= '0;
                        gate_en[0] <= 1'b1;
                    end
                end
                PH_RISE: begin
                    if (!all_good) begin
                        phase   <= PH_IDLE;
                        gate_en <= '0;
                    end else if (!en_act) begin
                        phase        <= PH_FALL;
                        gate_en[idx] <= 1'b0;
                    end else if (gate_on[idx]) begin
                        if (idx == TOP) begin
                            phase <= PH_ON;
                        end else begin
                            idx                 <= idx + 1'b1;
                            gate_en[idx + 1'b1] <= 1'b1;
                        end
                    end
                end
                PH_ON: begin
                    if (!all_good) begin
                        phase   <= PH_IDLE;
                        gate_en <= '0;
                    end else if (!en_act) begin
                        phase        <= PH_FALL;
                        idx          <= TOP;
                        gate_en[TOP] <= 1'b0;
                    end
                end
                default: begin
                    if (!all_good) begin
                        phase   <= PH_IDLE;
                        gate_en <= '0;
                    end else if (gate_off[idx]) begin
                        if (idx == '0) begin
                            phase <= PH_IDLE;
                        end else begin
                            idx                 <= idx - 1'b1;
                            gate_en[idx - 1'b1] <= 1'b0;
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/rcs_pg_timer.sv
// Module: power-good settle timer. Output rises PG_LEN cycles after active
// goes high and falls in the same cycle active falls.
// Assumes: active is a registered phase decode.
module rcs_pg_timer #(
    parameter int unsigned PG_LEN = 150000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic good
);
    import rcs_pkg::*;

    localparam int unsigned CW = cnt_width(PG_LEN);
    localparam logic [CW-1:0] DONE = CW'(PG_LEN);

    logic [CW-1:0] settle_cnt;

    // Saturating settle count while all rails are up
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            settle_cnt <= '0;
        end else if (settle_cnt != DONE) begin
            settle_cnt <= settle_cnt + 1'b1;
        end
    end

    // Good only while still active
    always_comb good = active && (settle_cnt == DONE);

endmodule

// File: rtl/rail_chain_seq.sv
// Module: top of the fixed-order chained rail sequencer. Filters the
// undervoltage flags, qualifies the start condition, runs the ordered
// chain and times the power-good output.
// Assumes: all inputs synchronous to clk; ramp status flags from outside.
module rail_chain_seq #(
    parameter int unsigned N_CH     = 4,
    parameter int unsigned FILT_LEN = 30,
    parameter int unsigned QUAL_LEN = 10000,
    parameter int unsigned PG_LEN   = 150000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] uv_ok,
    input  logic            en_n,
    input  logic [N_CH-1:0] gate_on,
    input  logic [N_CH-1:0] gate_off,
    output logic [N_CH-1:0] gate_en,
    output logic            pwr_good
);
    import rcs_pkg::*;

    logic [N_CH-1:0] uv_good;
    logic            all_good;
    logic            en_act;
    logic            start;
    seq_phase_t      phase;

    // One deglitcher per monitored rail
    for (genvar g = 0; g < N_CH; g++) begin : g_filt
        rcs_deglitch #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_in   (uv_ok[g]),
            .clean_out(uv_good[g])
        );
    end

    // Combined start condition terms
    always_comb begin
        all_good = &uv_good;
        en_act   = !en_n;
    end

    rcs_qualify #(.QUAL_LEN(QUAL_LEN)) u_qual (
        .clk  (clk),
        .rst_n(rst_n),
        .arm  (phase == PH_IDLE),
        .cond (all_good && en_act),
        .ready(start)
    );

    rcs_chain_fsm #(.N_CH(N_CH)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .all_good(all_good),
        .en_act  (en_act),
        .gate_on (gate_on),
        .gate_off(gate_off),
        .gate_en (gate_en),
        .phase   (phase)
    );

    rcs_pg_timer #(.PG_LEN(PG_LEN)) u_pg (
        .clk   (clk),
        .rst_n (rst_n),
        .active(phase == PH_ON),
        .good  (pwr_good)
    );

endmodule

// File: rtl/rail_chain_seq_chk.sv
// Module: assertion checker for rail_chain_seq, attached by bind.
// Assumes: uv_good is the filtered flag vector inside the top.
module rail_chain_seq_chk #(
    parameter int unsigned N_CH = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            en_n,
    input logic [N_CH-1:0] gate_on,
    input logic [N_CH-1:0] gate_en,
    input logic [N_CH-1:0] uv_good,
    input logic            pwr_good
);

    // Gates always form a run of ones from bit 0
    for (genvar k = 1; k < N_CH; k++) begin : g_order
        AST_GATE_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
            gate_en[k] |-> gate_en[k-1]); // R2
        AST_RISE_AFTER_PREV: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate_en[k]) |-> $past(gate_on[k-1])); // R2
    end

    AST_PG_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_good |-> (&gate_en)); // R5

    AST_PG_DROP_ON_DIS: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |=> !pwr_good); // R5

    AST_NO_RISE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |=> ((gate_en & ~$past(gate_en)) == '0)); // R4

    AST_FAULT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ((|gate_en) && !(&uv_good)) |=> ((gate_en == '0) && !pwr_good)); // R7

endmodule

bind rail_chain_seq rail_chain_seq_chk #(.N_CH(N_CH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_n    (en_n),
    .gate_on (gate_on),
    .gate_en (gate_en),
    .uv_good (uv_good),
    .pwr_good(pwr_good)
);

// File: tb/rail_chain_seq_tb.sv
module rail_chain_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int FILT = 4;
    localparam int QUAL = 20;
    localparam int PG   = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] uv_ok = 4'h0;
    logic       en_n = 1'b1;
    logic [3:0] gate_on = 4'h0;
    logic [3:0] gate_off = 4'h0;
    logic [3:0] gate_en;
    logic       pwr_good;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rail_chain_seq #(
        .N_CH(4), .FILT_LEN(FILT), .QUAL_LEN(QUAL), .PG_LEN(PG)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .uv_ok(uv_ok), .en_n(en_n),
        .gate_on(gate_on), .gate_off(gate_off),
        .gate_en(gate_en), .pwr_good(pwr_good)
    );

    // Advance n edges, land 1 time unit after the last
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk_gates(input string req, input logic [3:0] exp);
        n_chk++;
        if (gate_en !== exp) begin
            n_fail++;
            $display("FAIL %s gate_en actual=%b expected=%b", req, gate_en, exp);
        end
    endtask

    task automatic chk_pg(input string req, input logic exp);
        n_chk++;
        if (pwr_good !== exp) begin
            n_fail++;
            $display("FAIL %s pwr_good actual=%b expected=%b", req, pwr_good, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; uv_ok = 4'h0; en_n = 1'b1; gate_on = 4'h0; gate_off = 4'h0;
        step(3);
        chk_gates("R10", 4'h0);
        chk_pg("R10", 1'b0);
        rst_n = 1'b1;
        step(1);
    endtask

    // Qualify from reset and raise rail A (R1)
    task automatic qualify_up();
        uv_ok = 4'hF; en_n = 1'b0;
        step(FILT + QUAL);
        chk_gates("R1", 4'h0);
        step(1);
        chk_gates("R1", 4'b0001);
    endtask

    // Full rise to power-good
    task automatic t_power_up();
        do_reset();
        qualify_up();
        gate_on = 4'b0100;                 // out-of-turn flag, R9
        step(2);
        chk_gates("R9", 4'b0001);
        gate_on = 4'b0001; step(1); chk_gates("R2", 4'b0011);
        gate_on = 4'b0011; step(1); chk_gates("R2", 4'b0111);
        gate_on = 4'b0111; step(1); chk_gates("R2", 4'b1111);
        chk_pg("R5", 1'b0);
        gate_on = 4'b1111; step(1);
        chk_pg("R5", 1'b0);
        step(PG - 1); chk_pg("R5", 1'b0);
        step(1);      chk_pg("R5", 1'b1);
        chk_gates("R2", 4'b1111);
    endtask

    task automatic t_power_down();
        t_power_up();
        en_n = 1'b1; step(1);
        chk_gates("R3", 4'b0111); chk_pg("R5", 1'b0);
        step(2); chk_gates("R3", 4'b0111);
        gate_on = 4'b0111; gate_off = 4'b1000; step(1); chk_gates("R3", 4'b0011);
        gate_on = 4'b0011; gate_off = 4'b1100; step(1); chk_gates("R3", 4'b0001);
        gate_on = 4'b0001; gate_off = 4'b1110; step(1); chk_gates("R3", 4'b0000);
        gate_on = 4'b0000; gate_off = 4'b1111; step(1);
        gate_off = 4'b0000;
        en_n = 1'b0;                       // back in idle: filtered flags good
        step(QUAL); chk_gates("R3", 4'b0000);
        step(1);    chk_gates("R3", 4'b0001);
    endtask

    task automatic t_glitch();
        t_power_up();
        uv_ok = 4'b1101; step(FILT - 1);
        uv_ok = 4'hF;    step(3);
        chk_gates("R6", 4'b1111); chk_pg("R6", 1'b1);
    endtask

    task automatic t_fault();
        t_power_up();
        uv_ok = 4'b1011; step(FILT);
        chk_gates("R6", 4'b1111);
        step(1);
        chk_gates("R7", 4'b0000); chk_pg("R7", 1'b0);
        gate_on = 4'h0;
        uv_ok = 4'hF;
        step(FILT + QUAL); chk_gates("R7", 4'b0000);
        step(1);           chk_gates("R7", 4'b0001);
    endtask

    task automatic t_abort();
        do_reset();
        qualify_up();
        gate_on = 4'b0001; step(1); chk_gates("R8", 4'b0011);
        en_n = 1'b1; step(1); chk_gates("R8", 4'b0001);
        gate_on = 4'b0000; gate_off = 4'b0010; step(1); chk_gates("R8", 4'b0000);
        gate_off = 4'b0011; step(1);
        gate_off = 4'b0000; step(5);
        chk_gates("R4", 4'b0000);
    endtask

    task automatic t_disabled();
        do_reset();
        uv_ok = 4'hF; en_n = 1'b1;
        step(FILT + QUAL + 10);
        chk_gates("R4", 4'b0000); chk_pg("R4", 1'b0);
        en_n = 1'b0;
        step(QUAL); chk_gates("R1", 4'b0000);
        step(1);    chk_gates("R1", 4'b0001);
    endtask

    initial begin
        t_power_down();
        t_glitch();
        t_fault();
        t_abort();
        t_disabled();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule